// File: doc/BRIEF.md
# Immediate Prefix Fusion Decoder

This block sits inside an instruction decoder, after length decode. It takes one pre-decoded instruction record per cycle over a valid/ready handshake. A record is one of three kinds: an ordinary instruction, an immediate prefix, or a consumer instruction. A prefix carries a 2-, 4- or 8-byte immediate and a flag that picks sign or zero extension. The block widens the immediate to 64 bits and parks it in one of two constant slots. The slots fill in order.

A consumer instruction has no immediate field of its own. When one arrives, the block combines it with the slots filled before it into a single issued operation. That operation carries the consumer payload, both constants with their valid bits, and the address of the first prefix of the group. Because the group leaves as one operation, a fetch fault on any member is reported with the group start as the restart address. A separate fault data address points at the member that faulted. No constant survives the group, so nothing needs saving as thread state.

Sequences that break the rules are discarded and flagged for one cycle. A flush input drops any partly built group.

Top module: `imm_fuse_decoder`

## Requirements
- R1: After reset both slots are empty, `outValid` and `seqError` are low, and `inReady` is high when no record is offered.
- R2: A prefix immediate is widened according to `inImmSize`: 0 keeps bits 15:0, 1 keeps bits 31:0, 2 and 3 keep all 64 bits. When `inImmSext` is 1 the top kept bit is copied upward; when it is 0 the upper bits are zero.
- R3: Kind codes are 0 ordinary, 1 prefix, 2 consumer, and 3 behaves as ordinary. The first prefix of a group fills constant slot 0 and the second fills slot 1.
- R4: A consumer whose `inNeed` is not more than the number of filled slots is issued in the same cycle it is offered. The issued operation carries `inPayload`, both slots (a constant reads zero when its valid bit is low), and `outStartAddr` equal to the first prefix address, or to the consumer's own address if no slot is filled. An ordinary record with no filled slot is issued the same way, with both constant valid bits low.
- R5: Each of the following is an illegal sequence: a third prefix while both slots are filled, a consumer needing more slots than are filled, and an ordinary record while any slot is filled. The record is accepted and discarded, and no operation is issued. `seqError` is high for that cycle, with `seqErrAddr` set to the group start (or the record's own address if no slot is filled). Both slots are empty on the next cycle.
- R6: In the cycle an issued operation is accepted (`outValid` and `outReady` both high), both slots and the stored fault clear.
- R7: `outFault` is high if any record of the group arrived with `inFetchFault` set. `outFaultAddr` is the `inFaultAddr` of the earliest faulting record. `outStartAddr` stays at the group start.
- R8: While `flush` is high, no record is accepted and no operation is issued. On the next cycle both slots and the stored fault are clear.
- R9: While an operation is offered and `outReady` is low, `inReady` is low and the slot state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop any partial group |
| inValid | input | 1 | Input record valid |
| inReady | output | 1 | Input record accepted when high with inValid |
| inKind | input | 2 | 0 ordinary, 1 prefix, 2 consumer, 3 ordinary |
| inAddr | input | ADDR_W | Instruction address of the record |
| inPayload | input | PAY_W | Decoded payload of a consumer or ordinary record |
| inNeed | input | 2 | Number of constants a consumer requires |
| inImm | input | 64 | Raw prefix immediate, right aligned |
| inImmSize | input | 2 | 0: 2 bytes, 1: 4 bytes, 2 or 3: 8 bytes |
| inImmSext | input | 1 | 1 sign extend, 0 zero extend |
| inFetchFault | input | 1 | Fetch of this record faulted |
| inFaultAddr | input | ADDR_W | Faulting data address for this record |
| outValid | output | 1 | Issued operation valid |
| outReady | input | 1 | Downstream accepts operation |
| outPayload | output | PAY_W | Consumer payload |
| outConst0 | output | 64 | Constant from slot 0 |
| outConst0Valid | output | 1 | Slot 0 used |
| outConst1 | output | 64 | Constant from slot 1 |
| outConst1Valid | output | 1 | Slot 1 used |
| outStartAddr | output | ADDR_W | Restart address of the group |
| outFault | output | 1 | A group member faulted |
| outFaultAddr | output | ADDR_W | Faulting data address |
| seqError | output | 1 | Illegal sequence, one cycle |
| seqErrAddr | output | ADDR_W | Start address of the discarded group |

## Verification
Flush can be high in the same cycle that a record which would otherwise issue, load a slot or be flagged is offered. The random stream raises flush on a few percent of cycles, and directed steps place it under a waiting consumer. The bench expects no issue, no acceptance and no error in that cycle, and empty slots afterwards. Backpressure can also coincide with a fault on the consumer. There the bench checks that the fault data address and group start stay the same across the stall until the operation is taken.

// File: rtl/imm_fuse_pkg.sv
package imm_fuse_pkg;

  localparam int CONST_W = 64;

  typedef enum logic [1:0] {
    KIND_ORD = 2'd0,
    KIND_PRE = 2'd1,
    KIND_CON = 2'd2,
    KIND_RSV = 2'd3
  } kind_e;

  typedef struct packed {
    logic loadSlot0;
    logic loadSlot1;
    logic clearAll;
    logic latchFault;
  } strobes_t;

  function automatic logic [CONST_W-1:0] extendImm(
    input logic [CONST_W-1:0] raw,
    input logic [1:0]         size,
    input logic               sext
  );
    logic [CONST_W-1:0] res;
    case (size)
      2'd0:    res = {{(CONST_W-16){sext & raw[15]}}, raw[15:0]};
      2'd1:    res = {{(CONST_W-32){sext & raw[31]}}, raw[31:0]};
      default: res = raw;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/imm_fuse_ctrl.sv
module imm_fuse_ctrl
  import imm_fuse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       inValid,
  input  logic [1:0] inKind,
  input  logic [1:0] inNeed,
  input  logic       inFetchFault,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       seqError,
  output logic       slotValid0,
  output logic       slotValid1,
  output logic       faultSeen,
  output strobes_t   strobes
);

  logic       isPre, isCon, isOrd;
  logic [1:0] slotCount;
  logic       conOk, ordOk, issue, accept, badSeq;

  always_comb begin
    isPre     = inValid && (inKind == KIND_PRE);
    isCon     = inValid && (inKind == KIND_CON);
    isOrd     = inValid && (inKind != KIND_PRE) && (inKind != KIND_CON);
    slotCount = {1'b0, slotValid0} + {1'b0, slotValid1};
    conOk     = isCon && (inNeed <= slotCount);
    ordOk     = isOrd && (slotCount == 2'd0);
    issue     = !flush && (conOk || ordOk);
    inReady   = !flush && !(issue && !outReady);
    accept    = inValid && inReady;
    badSeq    = (isPre && slotValid1) || (isCon && !conOk) || (isOrd && !ordOk);
    seqError  = accept && badSeq;
    outValid  = issue;

    strobes.loadSlot0  = accept && isPre && !slotValid0;
    strobes.loadSlot1  = accept && isPre && slotValid0 && !slotValid1;
    strobes.clearAll   = flush || seqError || (accept && issue);
    strobes.latchFault = accept && isPre && !slotValid1 && inFetchFault && !faultSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid0 <= 1'b0;
      slotValid1 <= 1'b0;
      faultSeen  <= 1'b0;
    end else if (strobes.clearAll) begin
      slotValid0 <= 1'b0;
      slotValid1 <= 1'b0;
      faultSeen  <= 1'b0;
    end else begin
      if (strobes.loadSlot0)  slotValid0 <= 1'b1;
      if (strobes.loadSlot1)  slotValid1 <= 1'b1;
      if (strobes.latchFault) faultSeen  <= 1'b1;
    end
  end

  // R3: slot 1 is never filled ahead of slot 0
  a_r3_fill_order: assert property (@(posedge clk) disable iff (!rstN)
    slotValid1 |-> slotValid0);

  // R6: accepted operation empties the slots
  a_r6_clear_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (!slotValid0 && !slotValid1 && !faultSeen));

  // R5: illegal sequence empties the slots
  a_r5_error_clears: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> (!slotValid0 && !slotValid1));

  // R8: flush empties the slots
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!slotValid0 && !slotValid1 && !faultSeen));

  // R9: stalled operation holds the slot state
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=>
      (slotValid0 == $past(slotValid0) && slotValid1 == $past(slotValid1)));

endmodule

// File: rtl/imm_fuse_dpath.sv
module imm_fuse_dpath
  import imm_fuse_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int PAY_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic               slotValid0,
  input  logic               slotValid1,
  input  logic               faultSeen,
  input  logic [ADDR_W-1:0]  inAddr,
  input  logic [PAY_W-1:0]   inPayload,
  input  logic [CONST_W-1:0] inImm,
  input  logic [1:0]         inImmSize,
  input  logic               inImmSext,
  input  logic               inFetchFault,
  input  logic [ADDR_W-1:0]  inFaultAddr,
  output logic [PAY_W-1:0]   outPayload,
  output logic [CONST_W-1:0] outConst0,
  output logic [CONST_W-1:0] outConst1,
  output logic [ADDR_W-1:0]  outStartAddr,
  output logic               outFault,
  output logic [ADDR_W-1:0]  outFaultAddr
);

  logic [CONST_W-1:0] slotData0, slotData1, wideImm;
  logic [ADDR_W-1:0]  groupStart, faultAddrReg;

  assign wideImm = extendImm(inImm, inImmSize, inImmSext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotData0    <= '0;
      slotData1    <= '0;
      groupStart   <= '0;
      faultAddrReg <= '0;
    end else begin
      if (strobes.loadSlot0) begin
        slotData0  <= wideImm;
        groupStart <= inAddr;
      end
      if (strobes.loadSlot1)  slotData1    <= wideImm;
      if (strobes.latchFault) faultAddrReg <= inFaultAddr;
    end
  end

  always_comb begin
    outPayload   = inPayload;
    outConst0    = slotValid0 ? slotData0 : '0;
    outConst1    = slotValid1 ? slotData1 : '0;
    outStartAddr = slotValid0 ? groupStart : inAddr;
    outFault     = faultSeen || inFetchFault;
    outFaultAddr = faultSeen ? faultAddrReg : inFaultAddr;
  end

  // R7: the first recorded fault address is kept for the whole group
  a_r7_fault_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (faultSeen && $past(faultSeen)) |-> $stable(faultAddrReg));

  // R3: a single prefix never fills both slots
  a_r3_one_slot_per_prefix: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadSlot0, strobes.loadSlot1}));

endmodule

// File: rtl/imm_fuse_decoder.sv
module imm_fuse_decoder
  import imm_fuse_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int PAY_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               inValid,
  output logic               inReady,
  input  logic [1:0]         inKind,
  input  logic [ADDR_W-1:0]  inAddr,
  input  logic [PAY_W-1:0]   inPayload,
  input  logic [1:0]         inNeed,
  input  logic [63:0]        inImm,
  input  logic [1:0]         inImmSize,
  input  logic               inImmSext,
  input  logic               inFetchFault,
  input  logic [ADDR_W-1:0]  inFaultAddr,
  output logic               outValid,
  input  logic               outReady,
  output logic [PAY_W-1:0]   outPayload,
  output logic [63:0]        outConst0,
  output logic               outConst0Valid,
  output logic [63:0]        outConst1,
  output logic               outConst1Valid,
  output logic [ADDR_W-1:0]  outStartAddr,
  output logic               outFault,
  output logic [ADDR_W-1:0]  outFaultAddr,
  output logic               seqError,
  output logic [ADDR_W-1:0]  seqErrAddr
);

  strobes_t strobes;
  logic     slotValid0, slotValid1, faultSeen;

  imm_fuse_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .flush        (flush),
    .inValid      (inValid),
    .inKind       (inKind),
    .inNeed       (inNeed),
    .inFetchFault (inFetchFault),
    .outReady     (outReady),
    .inReady      (inReady),
    .outValid     (outValid),
    .seqError     (seqError),
    .slotValid0   (slotValid0),
    .slotValid1   (slotValid1),
    .faultSeen    (faultSeen),
    .strobes      (strobes)
  );

  imm_fuse_dpath #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .slotValid0   (slotValid0),
    .slotValid1   (slotValid1),
    .faultSeen    (faultSeen),
    .inAddr       (inAddr),
    .inPayload    (inPayload),
    .inImm        (inImm),
    .inImmSize    (inImmSize),
    .inImmSext    (inImmSext),
    .inFetchFault (inFetchFault),
    .inFaultAddr  (inFaultAddr),
    .outPayload   (outPayload),
    .outConst0    (outConst0),
    .outConst1    (outConst1),
    .outStartAddr (outStartAddr),
    .outFault     (outFault),
    .outFaultAddr (outFaultAddr)
  );

  assign outConst0Valid = slotValid0;
  assign outConst1Valid = slotValid1;
  assign seqErrAddr     = outStartAddr;

endmodule

// File: tb/imm_fuse_decoder_test.sv
`timescale 1ns/1ps
module imm_fuse_decoder_test;

  localparam int ADDR_W = 48;
  localparam int PAY_W  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, inValid = 1'b0, inImmSext = 1'b0, inFetchFault = 1'b0, outReady = 1'b1;
  logic [1:0] inKind = '0, inNeed = '0, inImmSize = '0;
  logic [ADDR_W-1:0] inAddr = '0, inFaultAddr = '0;
  logic [PAY_W-1:0] inPayload = '0;
  logic [63:0] inImm = '0;
  logic inReady, outValid, outConst0Valid, outConst1Valid, outFault, seqError;
  logic [PAY_W-1:0] outPayload;
  logic [63:0] outConst0, outConst1;
  logic [ADDR_W-1:0] outStartAddr, outFaultAddr, seqErrAddr;

  imm_fuse_decoder #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model state
  bit mv0, mv1, mFs;
  logic [63:0] mc0, mc1;
  logic [ADDR_W-1:0] mStart, mFa;

  function automatic logic [63:0] extRef(logic [63:0] raw, logic [1:0] sz, logic sx);
    logic [63:0] r;
    if (sz == 2'd0) r = sx && raw[15] ? (raw | ~64'hFFFF) : (raw & 64'hFFFF);
    else if (sz == 2'd1) r = sx && raw[31] ? (raw | ~64'hFFFF_FFFF) : (raw & 64'hFFFF_FFFF);
    else r = raw;
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // drive one record at the falling edge, check, then update the model at the rising edge
  task automatic step(string tag, bit v, logic [1:0] k, logic [ADDR_W-1:0] a,
                      logic [PAY_W-1:0] p, logic [1:0] nd, logic [63:0] im,
                      logic [1:0] sz, bit sx, bit ff, logic [ADDR_W-1:0] fa,
                      bit ordy, bit fl);
    bit isPre, isCon, eIssue, eReady, acc, eErr;
    int cnt;
    @(negedge clk);
    inValid = v; inKind = k; inAddr = a; inPayload = p; inNeed = nd; inImm = im;
    inImmSize = sz; inImmSext = sx; inFetchFault = ff; inFaultAddr = fa;
    outReady = ordy; flush = fl;
    #1;
    cnt = int'(mv0) + int'(mv1);
    isPre = v && k == 2'd1;
    isCon = v && k == 2'd2;
    eIssue = !fl && v && ((isCon && nd <= cnt) || (!isPre && !isCon && cnt == 0));
    eReady = !fl && !(eIssue && !ordy);
    acc = v && eReady;
    eErr = acc && ((isPre && mv1) || (isCon && nd > cnt) || (!isPre && !isCon && cnt != 0));
    chk(tag, "outValid", outValid, eIssue);
    chk("R9", "inReady", inReady, eReady);
    chk("R5", "seqError", seqError, eErr);
    if (eIssue) begin
      chk("R4", "payload", outPayload, p);
      chk("R3", "const0Valid", outConst0Valid, mv0);
      chk("R3", "const1Valid", outConst1Valid, mv1);
      chk("R2", "const0", outConst0, mv0 ? mc0 : 64'd0);
      chk("R2", "const1", outConst1, mv1 ? mc1 : 64'd0);
      chk("R4", "startAddr", outStartAddr, cnt != 0 ? mStart : a);
      chk("R7", "fault", outFault, mFs || ff);
      if (mFs || ff) chk("R7", "faultAddr", outFaultAddr, mFs ? mFa : fa);
    end
    if (eErr) chk("R5", "seqErrAddr", seqErrAddr, cnt != 0 ? mStart : a);
    @(posedge clk);
    if (fl || eErr || (acc && eIssue)) begin
      mv0 = 0; mv1 = 0; mFs = 0;
    end else if (acc && isPre) begin
      if (!mv0) begin mv0 = 1; mc0 = extRef(im, sz, sx); mStart = a; end
      else begin mv1 = 1; mc1 = extRef(im, sz, sx); end
      if (ff && !mFs) begin mFs = 1; mFa = fa; end
    end
  endtask

  task automatic idle(string tag);
    step(tag, 0, 2'd0, '0, '0, 2'd0, '0, 2'd0, 0, 0, '0, 1, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20250309);
    mv0 = 0; mv1 = 0; mFs = 0; mc0 = '0; mc1 = '0; mStart = '0; mFa = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1: idle state after reset
    idle("R1");
    chk("R1", "const0Valid idle", outConst0Valid, 0);
    chk("R1", "const1Valid idle", outConst1Valid, 0);

    // R2 R3 R4: two prefixes, sign-extended 16-bit and zero-extended 32-bit, then consumer
    step("R3", 1, 2'd1, 48'h1000, '0, 0, 64'h8001, 2'd0, 1, 0, '0, 1, 0);
    step("R3", 1, 2'd1, 48'h1004, '0, 0, 64'hFFFF_FFFF_8000_0001, 2'd1, 0, 0, '0, 1, 0);
    step("R4", 1, 2'd2, 48'h1008, 32'hCAFE, 2'd2, '0, 0, 0, 0, '0, 1, 0);
    // R4: ordinary issue with empty slots
    step("R4", 1, 2'd0, 48'h2000, 32'h1111, 0, '0, 0, 0, 0, '0, 1, 0);
    // R5: third prefix
    step("R5", 1, 2'd1, 48'h3000, '0, 0, 64'h7FFF, 2'd0, 1, 0, '0, 1, 0);
    step("R5", 1, 2'd1, 48'h3004, '0, 0, 64'h1, 2'd2, 0, 0, '0, 1, 0);
    step("R5", 1, 2'd1, 48'h3008, '0, 0, 64'h2, 2'd2, 0, 0, '0, 1, 0);
    // R5: consumer needing two with one filled; ordinary after prefix
    step("R5", 1, 2'd1, 48'h3100, '0, 0, 64'h5, 2'd3, 0, 0, '0, 1, 0);
    step("R5", 1, 2'd2, 48'h3104, 32'h2, 2'd2, '0, 0, 0, 0, '0, 1, 0);
    step("R5", 1, 2'd1, 48'h3200, '0, 0, 64'h6, 2'd1, 1, 0, '0, 1, 0);
    step("R5", 1, 2'd3, 48'h3204, 32'h3, 0, '0, 0, 0, 0, '0, 1, 0);
    // R7 R9: fault on the consumer under backpressure, R6 slots cleared after accept
    step("R7", 1, 2'd1, 48'h4000, '0, 0, 64'hABCD, 2'd0, 0, 0, '0, 1, 0);
    step("R9", 1, 2'd2, 48'h4004, 32'h44, 2'd1, '0, 0, 0, 1, 48'h4006, 0, 0);
    step("R9", 1, 2'd2, 48'h4004, 32'h44, 2'd1, '0, 0, 0, 1, 48'h4006, 0, 0);
    step("R7", 1, 2'd2, 48'h4004, 32'h44, 2'd1, '0, 0, 0, 1, 48'h4006, 1, 0);
    step("R6", 1, 2'd2, 48'h4010, 32'h45, 2'd1, '0, 0, 0, 0, '0, 1, 0);
    // R7: fault on first prefix wins over later one
    step("R7", 1, 2'd1, 48'h5000, '0, 0, 64'h1, 2'd0, 0, 1, 48'h5001, 1, 0);
    step("R7", 1, 2'd1, 48'h5004, '0, 0, 64'h2, 2'd0, 0, 1, 48'h5005, 1, 0);
    step("R7", 1, 2'd2, 48'h5008, 32'h77, 2'd2, '0, 0, 0, 0, '0, 1, 0);
    // R8: flush under a waiting consumer, then a consumer that now lacks its slot
    step("R8", 1, 2'd1, 48'h6000, '0, 0, 64'h9, 2'd0, 0, 0, '0, 1, 0);
    step("R8", 1, 2'd2, 48'h6004, 32'h88, 2'd1, '0, 0, 0, 0, '0, 1, 1);
    step("R8", 1, 2'd2, 48'h6004, 32'h88, 2'd1, '0, 0, 0, 0, '0, 1, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] k;
      int r;
      r = int'($urandom % 10);
      k = (r < 5) ? 2'd1 : (r < 8) ? 2'd2 : 2'($urandom % 4);
      step("R4", ($urandom % 8) != 0, k, 48'($urandom), 32'($urandom), 2'($urandom % 3),
           {32'($urandom), 32'($urandom)}, 2'($urandom), 1'($urandom),
           ($urandom % 6) == 0, 48'($urandom), ($urandom % 4) != 0, ($urandom % 25) == 0);
    end
    idle("R1");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule